// File: doc/BRIEF.md
# Iterative CORDIC Vector Rotator

This block is a time-shared circular CORDIC engine. A request is a signed vector (x, y), a signed angle z and a mode bit. It either turns the vector through the angle (rotation) or turns the vector onto the positive x axis and adds the swept angle to z (vectoring). The block runs a fixed list of micro-rotations. Each one uses only shifts, adds and an entry from a built-in table of step angles, and the working vector is fed back through the same hardware on every clock.

A parameter sets how many micro-rotation stages are chained inside one clock. This trades adder area against the number of cycles per request. When the chain covers every iteration, the shift distances become fixed wiring. A second parameter selects whether the inherent vector growth is removed at the output by a four-term shift-and-add scaler, or whether the raw grown vector is passed out. A request is accepted with a one-cycle strobe while the engine is idle. Completion is marked by a single-cycle flag, and the results then stay on the outputs until the next request is accepted.

Angles use binary units: a signed DATA_W-bit word in which 2^(DATA_W-1) stands for pi radians. Angle arithmetic therefore wraps modulo one full turn.

Top module: `cordic_iter`

## Requirements
- R1: After reset, done is 0 and xOut, yOut and zOut are all 0.
- R2: An init pulse seen while idle is accepted at that clock edge. done is then high for exactly one cycle, starting ITERS/UNROLL clock edges after the accepting edge (11 falling edges after init is first driven, with the defaults).
- R3: An init pulse that arrives while an operation is in progress is ignored. The result, the done timing and the number of done pulses all match an undisturbed run.
- R4: With vecMode = 0 (rotation), each step turns in the positive direction when the residual angle is zero or positive, and in the negative direction otherwise. For |zIn| <= 2^(DATA_W-2) (±pi/2), the output is (xIn·cos θ − yIn·sin θ, xIn·sin θ + yIn·cos θ)·S, with θ = zIn·pi/2^(DATA_W-1), and zOut lies near 0.
- R5: With vecMode = 1 (vectoring), each step turns in the positive direction when the residual y is negative, and in the negative direction otherwise. For xIn > 0, xOut = |(xIn, yIn)|·S, yOut lies near 0, and zOut = zIn + atan2(yIn, xIn) in angle units.
- R6: The x and y outputs lie within S·|v|·2^-(ITERS-2) + 20 LSB of the ideal value. zOut lies within 2^(DATA_W-1)/pi·2^-(ITERS-2) + 24 LSB of the ideal value (modulo 2^DATA_W).
- R7: The scale factor S is the product over all iterations i of sqrt(1 + 2^-2i), multiplied by (2^-1 + 2^-3 − 2^-6 − 2^-9) when APPLY_GAIN = 1, and by 1 when APPLY_GAIN = 0. z is never scaled.
- R8: With UNROLL stages per clock, one request takes ITERS/UNROLL cycles and meets the same accuracy as UNROLL = 1.
- R9: Outputs hold their values from done until the next accepted init. zOut wraps modulo 2^DATA_W.
- R10: x and y are carried with two guard bits (outputs are DATA_W+2 bits), so full-scale inputs of either sign never overflow.
- R11: The mode and the operands are captured at the accepting edge. Later changes to vecMode, xIn, yIn or zIn during the operation have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| init | input | 1 | Start strobe, accepted only when idle |
| vecMode | input | 1 | 0 = rotation, 1 = vectoring |
| xIn | input | DATA_W | Signed x operand |
| yIn | input | DATA_W | Signed y operand |
| zIn | input | DATA_W | Signed angle, 2^(DATA_W-1) = pi |
| xOut | output | DATA_W+2 | Signed x result |
| yOut | output | DATA_W+2 | Signed y result |
| zOut | output | DATA_W | Signed angle result |
| done | output | 1 | One-cycle completion flag |

## Verification
Rotation is tried with random vectors and angles up to ±pi/2, plus quarter-turn and zero-angle cases, which separate a wrong z-sign decision from a wrong y-sign decision. Vectoring is tried with random vectors in the right half plane, with negative-y vectors and with a full-scale diagonal. The diagonal exposes missing guard bits, and an angle offset near the top of the range shows whether z wraps. Every request runs at once on a one-stage instance with gain correction and on a two-stage instance without it, so a scaler fault or an unrolled-index fault shows up in only one of the two. Some requests receive a second init, a flipped mode and new operands mid-run, which must leave both the result and the completion timing unchanged.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  localparam int IDX_W = 8;
  localparam real CORDIC_PI = 3.14159265358979;

  typedef struct packed {
    logic             load;
    logic             advance;
    logic [IDX_W-1:0] iterBase;
  } cordic_ctl_t;

  // atan(2^-idx) in binary angle units, 2^(angW-1) == pi
  function automatic int stepAngle(input int idx, input int angW);
    real t;
    real t2;
    real pw;
    real acc;
    if (idx == 0) begin
      acc = CORDIC_PI / 4.0;
    end else begin
      t   = 1.0 / (2.0 ** idx);
      t2  = t * t;
      pw  = t;
      acc = 0.0;
      for (int k = 0; k < 24; k++) begin
        if (k % 2 == 0) acc = acc + pw / real'(2 * k + 1);
        else            acc = acc - pw / real'(2 * k + 1);
        pw = pw * t2;
      end
    end
    return $rtoi(acc * (2.0 ** (angW - 1)) / CORDIC_PI + 0.5);
  endfunction

endpackage

// File: rtl/cordic_ctrl.sv
module cordic_ctrl
  import cordic_pkg::*;
#(
  parameter int ITERS  = 10,
  parameter int UNROLL = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        init,
  output cordic_ctl_t ctl,
  output logic        busy,
  output logic        done
);
  localparam int PASSES = ITERS / UNROLL;
  localparam int CNT_W  = (PASSES > 1) ? $clog2(PASSES) : 1;

  logic [CNT_W-1:0] passCnt;
  logic             accept;

  assign accept = init && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      passCnt <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        passCnt <= '0;
      end else if (busy) begin
        if (passCnt == CNT_W'(PASSES - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
        passCnt <= passCnt + 1'b1;
      end
    end
  end

  always_comb begin
    ctl.load     = accept;
    ctl.advance  = busy;
    ctl.iterBase = IDX_W'(int'(passCnt) * UNROLL);
  end

endmodule

// File: rtl/cordic_stage.sv
module cordic_stage
  import cordic_pkg::*;
#(
  parameter int ANG_W = 16,
  parameter int VEC_W = 18
) (
  input  logic signed [VEC_W-1:0] xCur,
  input  logic signed [VEC_W-1:0] yCur,
  input  logic signed [ANG_W-1:0] zCur,
  input  logic        [IDX_W-1:0] shiftAmt,
  input  logic        [ANG_W-1:0] stepAng,
  input  logic                    vecMode,
  output logic signed [VEC_W-1:0] xNxt,
  output logic signed [VEC_W-1:0] yNxt,
  output logic signed [ANG_W-1:0] zNxt
);
  logic                    dirPos;
  logic signed [VEC_W-1:0] xShift;
  logic signed [VEC_W-1:0] yShift;

  // rotation follows the residual angle, vectoring opposes the residual y
  assign dirPos = vecMode ? yCur[VEC_W-1] : !zCur[ANG_W-1];

  assign xShift = xCur >>> shiftAmt;
  assign yShift = yCur >>> shiftAmt;

  // conditional subtract: invert operand and inject a matching carry
  assign xNxt = xCur + (yShift ^ {VEC_W{dirPos}}) + VEC_W'(dirPos);
  assign yNxt = yCur + (xShift ^ {VEC_W{!dirPos}}) + VEC_W'(!dirPos);
  assign zNxt = zCur + (stepAng ^ {ANG_W{dirPos}}) + ANG_W'(dirPos);

endmodule

// File: rtl/cordic_gain.sv
module cordic_gain #(
  parameter int VEC_W      = 18,
  parameter bit APPLY_GAIN = 1'b1
) (
  input  logic signed [VEC_W-1:0] vIn,
  output logic signed [VEC_W-1:0] vOut
);
  generate
    if (APPLY_GAIN) begin : g_scale
      // ~0.60742 = 1/2 + 1/8 - 1/64 - 1/512
      assign vOut = (vIn >>> 1) + (vIn >>> 3) - (vIn >>> 6) - (vIn >>> 9);
    end else begin : g_raw
      assign vOut = vIn;
    end
  endgenerate
endmodule

// File: rtl/cordic_datapath.sv
module cordic_datapath
  import cordic_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ITERS      = 10,
  parameter int UNROLL     = 1,
  parameter bit APPLY_GAIN = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cordic_ctl_t              ctl,
  input  logic                     vecMode,
  input  logic signed [DATA_W-1:0] xIn,
  input  logic signed [DATA_W-1:0] yIn,
  input  logic signed [DATA_W-1:0] zIn,
  output logic signed [DATA_W+1:0] xOut,
  output logic signed [DATA_W+1:0] yOut,
  output logic signed [DATA_W-1:0] zOut
);
  localparam int VEC_W = DATA_W + 2;
  localparam int TAB_W = (ITERS > 1) ? $clog2(ITERS) : 1;

  logic        [DATA_W-1:0] angTab [ITERS];
  logic signed [VEC_W-1:0]  xReg;
  logic signed [VEC_W-1:0]  yReg;
  logic signed [DATA_W-1:0] zReg;
  logic                     modeReg;

  logic signed [VEC_W-1:0]  xChain [UNROLL+1];
  logic signed [VEC_W-1:0]  yChain [UNROLL+1];
  logic signed [DATA_W-1:0] zChain [UNROLL+1];

  genvar g;
  generate
    for (g = 0; g < ITERS; g++) begin : g_tab
      assign angTab[g] = DATA_W'(stepAngle(g, DATA_W));
    end
  endgenerate

  assign xChain[0] = xReg;
  assign yChain[0] = yReg;
  assign zChain[0] = zReg;

  generate
    for (g = 0; g < UNROLL; g++) begin : g_stage
      logic [IDX_W-1:0] iterIdx;
      assign iterIdx = ctl.iterBase + IDX_W'(g);
      cordic_stage #(.ANG_W(DATA_W), .VEC_W(VEC_W)) i_stage (
        .xCur    (xChain[g]),
        .yCur    (yChain[g]),
        .zCur    (zChain[g]),
        .shiftAmt(iterIdx),
        .stepAng (angTab[iterIdx[TAB_W-1:0]]),
        .vecMode (modeReg),
        .xNxt    (xChain[g+1]),
        .yNxt    (yChain[g+1]),
        .zNxt    (zChain[g+1])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xReg    <= '0;
      yReg    <= '0;
      zReg    <= '0;
      modeReg <= 1'b0;
    end else if (ctl.load) begin
      xReg    <= {{2{xIn[DATA_W-1]}}, xIn};
      yReg    <= {{2{yIn[DATA_W-1]}}, yIn};
      zReg    <= zIn;
      modeReg <= vecMode;
    end else if (ctl.advance) begin
      xReg <= xChain[UNROLL];
      yReg <= yChain[UNROLL];
      zReg <= zChain[UNROLL];
    end
  end

  cordic_gain #(.VEC_W(VEC_W), .APPLY_GAIN(APPLY_GAIN)) i_gainX (.vIn(xReg), .vOut(xOut));
  cordic_gain #(.VEC_W(VEC_W), .APPLY_GAIN(APPLY_GAIN)) i_gainY (.vIn(yReg), .vOut(yOut));
  assign zOut = zReg;

endmodule

// File: rtl/cordic_iter.sv
module cordic_iter
  import cordic_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ITERS      = 10,
  parameter int UNROLL     = 1,
  parameter bit APPLY_GAIN = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     init,
  input  logic                     vecMode,
  input  logic signed [DATA_W-1:0] xIn,
  input  logic signed [DATA_W-1:0] yIn,
  input  logic signed [DATA_W-1:0] zIn,
  output logic signed [DATA_W+1:0] xOut,
  output logic signed [DATA_W+1:0] yOut,
  output logic signed [DATA_W-1:0] zOut,
  output logic                     done
);
  cordic_ctl_t ctl;
  logic        busy;

  cordic_ctrl #(.ITERS(ITERS), .UNROLL(UNROLL)) i_ctrl (
    .clk (clk),
    .rstN(rstN),
    .init(init),
    .ctl (ctl),
    .busy(busy),
    .done(done)
  );

  cordic_datapath #(
    .DATA_W(DATA_W), .ITERS(ITERS), .UNROLL(UNROLL), .APPLY_GAIN(APPLY_GAIN)
  ) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .vecMode(vecMode),
    .xIn    (xIn),
    .yIn    (yIn),
    .zIn    (zIn),
    .xOut   (xOut),
    .yOut   (yOut),
    .zOut   (zOut)
  );

endmodule

// File: rtl/cordic_iter_chk.sv
module cordic_iter_chk #(
  parameter int DATA_W = 16,
  parameter int ITERS  = 10,
  parameter int UNROLL = 1
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     init,
  input logic                     busy,
  input logic                     done,
  input logic signed [DATA_W+1:0] xOut,
  input logic signed [DATA_W+1:0] yOut,
  input logic signed [DATA_W-1:0] zOut
);
  logic [15:0] busyLen;

  always_ff @(posedge clk) begin
    if (!rstN)     busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else           busyLen <= '0;
  end

  // R2: completion flag lasts one cycle
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2, R8: completion after exactly ITERS/UNROLL busy cycles
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyLen == 16'(ITERS / UNROLL)));

  // R3: an operation ends only through the completion flag
  assert_busy_ends_with_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

  // R9: results hold while idle and no request arrives
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !init) |=> ($stable(xOut) && $stable(yOut) && $stable(zOut)));

  // R2: only an accepted init starts work
  assert_start_by_init_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !init) |=> !busy);

endmodule

bind cordic_iter cordic_iter_chk #(
  .DATA_W(DATA_W), .ITERS(ITERS), .UNROLL(UNROLL)
) i_chk (
  .clk (clk),
  .rstN(rstN),
  .init(init),
  .busy(busy),
  .done(done),
  .xOut(xOut),
  .yOut(yOut),
  .zOut(zOut)
);

// File: tb/test_cordic_iter.sv
module test_cordic_iter;
  localparam int    DW    = 16;
  localparam int    NIT   = 10;
  localparam real   PI    = 3.14159265358979;
  localparam real   KAPP  = 0.607421875;
  localparam int    PA    = NIT;
  localparam int    PB    = NIT / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic init = 1'b0;
  logic vecMode = 1'b0;
  logic signed [DW-1:0] xIn = '0, yIn = '0, zIn = '0;
  logic signed [DW+1:0] xA, yA, xB, yB;
  logic signed [DW-1:0] zA, zB;
  logic doneA, doneB;

  int nChecks = 0;
  int nFails  = 0;
  real growth;

  always #4 clk = ~clk;

  cordic_iter #(.DATA_W(DW), .ITERS(NIT), .UNROLL(1), .APPLY_GAIN(1'b1)) i_cordic_iter (
    .clk(clk), .rstN(rstN), .init(init), .vecMode(vecMode),
    .xIn(xIn), .yIn(yIn), .zIn(zIn),
    .xOut(xA), .yOut(yA), .zOut(zA), .done(doneA));

  cordic_iter #(.DATA_W(DW), .ITERS(NIT), .UNROLL(2), .APPLY_GAIN(1'b0)) i_cordic_iter_u2 (
    .clk(clk), .rstN(rstN), .init(init), .vecMode(vecMode),
    .xIn(xIn), .yIn(yIn), .zIn(zIn),
    .xOut(xB), .yOut(yB), .zOut(zB), .done(doneB));

  task automatic checkInt(input bit ok, input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic checkNear(input string tag, input string what, input int act, input real exp, input real tol);
    real diff;
    diff = real'(act) - exp;
    if (diff < 0.0) diff = -diff;
    checkInt(diff <= tol, tag, what, act, $rtoi(exp));
  endtask

  task automatic checkAng(input string tag, input string what, input int act, input real exp, input real tol);
    int d;
    d = act - $rtoi(exp + ((exp >= 0.0) ? 0.5 : -0.5));
    d = ((d % 65536) + 65536 + 32768) % 65536 - 32768;
    if (d < 0) d = -d;
    checkInt(real'(d) <= tol, tag, what, act, $rtoi(exp));
  endtask

  task automatic runOp(input bit vm, input int x, input int y, input int z, input bit disturb, input string tag);
    int firstA, firstB, hiA, hiB;
    real th, ex, ey, ez, mag, sA, sB, tolA, tolB, tolZ;
    @(negedge clk);
    vecMode = vm; xIn = DW'(x); yIn = DW'(y); zIn = DW'(z); init = 1'b1;
    firstA = 0; firstB = 0; hiA = 0; hiB = 0;
    for (int c = 1; c <= PA + 3; c++) begin
      @(negedge clk);
      if (c == 1) init = 1'b0;
      if (disturb && c == 2) begin
        init = 1'b1; vecMode = !vm; xIn = ~xIn; yIn = DW'(y + 1234); zIn = DW'(z - 5000);
      end
      if (disturb && c == 3) init = 1'b0;
      if (doneA) begin hiA++; if (firstA == 0) firstA = c; end
      if (doneB) begin hiB++; if (firstB == 0) firstB = c; end
    end
    checkInt(firstA == PA + 1, disturb ? "R3" : "R2", "done edge k1", firstA, PA + 1);
    checkInt(hiA == 1, disturb ? "R3" : "R2", "done count k1", hiA, 1);
    checkInt(firstB == PB + 1, "R8", "done edge k2", firstB, PB + 1);
    checkInt(hiB == 1, "R8", "done count k2", hiB, 1);
    mag = $sqrt(real'(x) * real'(x) + real'(y) * real'(y));
    sA = growth * KAPP;
    sB = growth;
    tolA = sA * mag * (2.0 ** (-(NIT - 2))) + 20.0;
    tolB = sB * mag * (2.0 ** (-(NIT - 2))) + 20.0;
    tolZ = (2.0 ** (DW - 1)) / PI * (2.0 ** (-(NIT - 2))) + 24.0;
    if (!vm) begin
      th = real'(z) * PI / (2.0 ** (DW - 1));
      ex = real'(x) * $cos(th) - real'(y) * $sin(th);
      ey = real'(x) * $sin(th) + real'(y) * $cos(th);
      ez = 0.0;
    end else begin
      ex = mag;
      ey = 0.0;
      ez = real'(z) + $atan2(real'(y), real'(x)) * (2.0 ** (DW - 1)) / PI;
    end
    checkNear(tag, "x k1 gain", int'(xA), ex * sA, tolA);
    checkNear(tag, "y k1 gain", int'(yA), ey * sA, tolA);
    checkAng(tag, "z k1", int'(zA), ez, tolZ);
    checkNear("R7", "x k2 raw", int'(xB), ex * sB, tolB);
    checkNear("R7", "y k2 raw", int'(yB), ey * sB, tolB);
    checkAng("R8", "z k2", int'(zB), ez, tolZ);
  endtask

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int seedInit;
    growth = 1.0;
    for (int i = 0; i < NIT; i++) growth = growth * $sqrt(1.0 + 2.0 ** (-2 * i));
    seedInit = $urandom(20240611);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    checkInt(doneA == 1'b0, "R1", "done", int'(doneA), 0);
    checkInt(xA == '0 && yA == '0, "R1", "xy", int'(xA) + int'(yA), 0);
    checkInt(zA == '0, "R1", "z", int'(zA), 0);

    // directed rotation cases, R4
    runOp(1'b0, 30000, 0, 0, 1'b0, "R4");
    runOp(1'b0, 1000, 0, 16384, 1'b0, "R4");
    runOp(1'b0, 1000, 0, -16384, 1'b0, "R4");
    runOp(1'b0, 0, 20000, 8192, 1'b0, "R4");
    // guard bits, R10
    runOp(1'b0, -32768, -32768, 8192, 1'b0, "R10");
    runOp(1'b1, 32767, -32768, 0, 1'b0, "R10");
    runOp(1'b1, 32767, 32767, 0, 1'b0, "R10");
    // directed vectoring, R5
    runOp(1'b1, 12000, 0, 0, 1'b0, "R5");
    runOp(1'b1, 5000, -15000, 1000, 1'b0, "R5");
    // z wrap, R9
    runOp(1'b1, 8000, 8000, 30000, 1'b0, "R9");
    // disturbed runs: R3 and R11
    runOp(1'b0, 12345, -6789, 9000, 1'b1, "R11");
    runOp(1'b1, 20000, 7000, -3000, 1'b1, "R11");

    // random cases, R6
    for (int n = 0; n < 40; n++) begin
      int x, y, z;
      x = int'($urandom_range(65535)) - 32768;
      y = int'($urandom_range(65535)) - 32768;
      z = int'($urandom_range(32768)) - 16384;
      runOp(1'b0, x, y, z, 1'b0, "R6");
    end
    for (int n = 0; n < 40; n++) begin
      int x, y, z;
      x = 2000 + int'($urandom_range(30767));
      y = int'($urandom_range(65535)) - 32768;
      z = int'($urandom_range(65535)) - 32768;
      runOp(1'b1, x, y, z, 1'b0, "R6");
    end

    // R9: results held long after completion
    repeat (20) @(negedge clk);
    checkInt(doneA == 1'b0, "R9", "done idle", int'(doneA), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule